// File: doc/BRIEF.md
# Receive-Only I2C Target with Register-Select Addressing

This block is the serial front end of a device that only listens on an I2C bus. It oversamples the SCL and SDA lines with the system clock, finds start and stop conditions, and reads the first byte of each transfer as an address. The upper six bits of the 7-bit address are compared with a 6-bit identity code set on input pins. The lowest address bit is not part of the identity. It is kept as a register-select flag that marks every following byte as either a command (instruction) or a memory data write.

When the address matches and the transfer is a write, the block pulls SDA low in the ninth clock. Every byte after that is shifted in, acknowledged in the same way, and handed to the consumer on a one-cycle strobe, together with the latched select flag. SDA is only ever pulled low, through an output-enable pin that drives an external open-drain pad. A stop ends the transfer. A repeated start begins a new address phase.

The controller is one state machine with six states:
- RX_IDLE waits for a start.
- RX_ADDR shifts in the address byte.
- RX_ADDR_ACK holds the acknowledge for a matched address.
- RX_DATA shifts in a payload byte.
- RX_DATA_ACK holds the acknowledge for that byte.
- RX_SKIP ignores the bus after a rejected address.

The transitions are:
- Start, from any state, goes to RX_ADDR.
- Stop, from any state, goes to RX_IDLE.
- RX_ADDR goes to RX_ADDR_ACK on the SCL fall after the eighth bit when the address matches and the write bit is zero. Otherwise it goes to RX_SKIP.
- RX_ADDR_ACK goes to RX_DATA on the SCL fall that ends the ninth clock.
- RX_DATA goes to RX_DATA_ACK on the SCL fall after the eighth bit.
- RX_DATA_ACK goes back to RX_DATA on the SCL fall that ends the ninth clock.

Top module: `i2c_rx_regsel`

## Requirements
- R1: A falling SDA while SCL is high is a start. From any state, including the middle of a payload (repeated start), it begins a fresh address reception.
- R2: The block is selected only when address-byte bits 7:2 equal `dev_id_i`. On a mismatch it leaves SDA released in the ninth clock. It then ignores every bit, producing no acknowledge and no strobe, until the next start or stop.
- R3: The address byte's bit 0 is the read/write bit. If it is 1, the block does not acknowledge and ignores the transfer as in R2.
- R4: Address-byte bit 1 is latched as the register select. `regsel_o` = 0 marks the following bytes as instructions, and 1 marks them as RAM data. It accompanies every strobed byte of that transfer.
- R5: After a selected address byte and after each payload byte, `sda_oe_o` is 1 for the whole ninth SCL clock, so the line is pulled low. `sda_oe_o` rises and falls only while SCL is low. The block has no output that drives SDA high.
- R6: Each payload byte, received MSB first, is presented on `byte_o` with a `byte_vld_o` pulse exactly one system clock long.
- R7: Any number of bytes may follow in one transfer until a stop. After a stop, bytes are ignored until a start.
- R8: While `rst_n` is low and after it is released, the block is idle with `sda_oe_o` = 0 and `byte_vld_o` = 0.
- R9: `sda_oe_o` returns to 0 shortly after the SCL fall that ends the ninth clock, before the next bit is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level, as seen on the wired bus |
| dev_id_i | input | 6 | Identity code compared with address bits 7:2 |
| sda_oe_o | output | 1 | 1 pulls SDA low through an open-drain pad, 0 releases it |
| byte_vld_o | output | 1 | One-cycle strobe for each received payload byte |
| byte_o | output | 8 | Received payload byte |
| regsel_o | output | 1 | Latched select: 0 instruction, 1 RAM data |

## Verification
The assertions assume a well-behaved controller on the bus. SDA changes only while SCL is low, except for start and stop, and each SCL half period lasts several system clocks, so the two-flop synchronizer settles before the next edge. The assertions also assume that no stop or start is issued in the middle of an acknowledge clock. The bench keeps to these assumptions:
- It drives SDA at the midpoint of each SCL low phase.
- It holds each half period for twelve clocks.
- It forms the line as the AND of its own drive and the block's pull-down.
- It issues repeated starts and stops only from a low-SCL point after an acknowledge clock has completed.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;
    localparam int BYTE_W = 8;
    localparam int ID_W   = 6;

    typedef enum logic [2:0] {
        RX_IDLE     = 3'd0,
        RX_ADDR     = 3'd1,
        RX_ADDR_ACK = 3'd2,
        RX_DATA     = 3'd3,
        RX_DATA_ACK = 3'd4,
        RX_SKIP     = 3'd5
    } rx_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= line_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
    parameter int W     = 8,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          shift_i,
    input  logic          bit_i,
    output logic [W-1:0]  data_o,
    output logic [CW-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (shift_i) begin
            data_o  <= {data_o[W-2:0], bit_i};
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_rx_regsel.sv
module i2c_rx_regsel
    import i2crx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ID_W-1:0]   dev_id_i,
    output logic              sda_oe_o,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              regsel_o
);
    localparam int CW = $clog2(BYTE_W + 1);
    localparam logic [CW-1:0] FULL = CW'(BYTE_W);

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;
    logic sh_clear, sh_shift;
    logic [BYTE_W-1:0] sh_data;
    logic [CW-1:0]     sh_cnt;
    logic              addr_ok;
    rx_state_e state_q, state_d;

    line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

    line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;

    assign sh_shift = scl_rise && (sh_cnt != FULL) &&
                      (state_q == RX_ADDR || state_q == RX_DATA);
    assign sh_clear = start_det ||
                      (scl_fall && (state_q == RX_ADDR_ACK || state_q == RX_DATA_ACK));

    rx_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear_i(sh_clear), .shift_i(sh_shift),
        .bit_i(sda_lvl), .data_o(sh_data), .count_o(sh_cnt));

    assign addr_ok = (sh_data[BYTE_W-1:2] == dev_id_i) && !sh_data[0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = RX_IDLE;
        end else if (start_det) begin
            state_d = RX_ADDR;
        end else begin
            unique case (state_q)
                RX_IDLE:     state_d = RX_IDLE;
                RX_ADDR:     if (scl_fall && sh_cnt == FULL)
                                 state_d = addr_ok ? RX_ADDR_ACK : RX_SKIP;
                RX_ADDR_ACK: if (scl_fall) state_d = RX_DATA;
                RX_DATA:     if (scl_fall && sh_cnt == FULL) state_d = RX_DATA_ACK;
                RX_DATA_ACK: if (scl_fall) state_d = RX_DATA;
                RX_SKIP:     state_d = RX_SKIP;
                default:     state_d = RX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o   <= 1'b0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
            regsel_o   <= 1'b0;
        end else begin
            sda_oe_o   <= (state_d == RX_ADDR_ACK) || (state_d == RX_DATA_ACK);
            byte_vld_o <= (state_q == RX_DATA) && (state_d == RX_DATA_ACK);
            if (state_q == RX_DATA && state_d == RX_DATA_ACK)
                byte_o <= sh_data;
            if (state_q == RX_ADDR && state_d == RX_ADDR_ACK)
                regsel_o <= sh_data[1];
        end
    end

    // R5: pull-down switches only while SCL is low
    a_r5_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl);
    a_r5_oe_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> !scl_lvl);
    // R6: strobe is a single cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |=> !byte_vld_o);
    // R2, R3: address acknowledged only for matching ID and write
    a_r2_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_ADDR_ACK && $past(state_q) != RX_ADDR_ACK) |->
        (sh_data[BYTE_W-1:2] == dev_id_i && !sh_data[0]));
    // R7: stop returns to idle with line released
    a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == RX_IDLE && !byte_vld_o));
    // R2: skip state never acknowledges
    a_r2_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_SKIP && $past(state_q) == RX_SKIP) |-> !sda_oe_o);
endmodule

// File: tb/i2c_rx_regsel_tb.sv
module i2c_rx_regsel_tb_top;
    localparam int H = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [5:0] dev_id = 6'b011101;
    logic       sda_oe, byte_vld, regsel;
    logic [7:0] byte_out;
    wire        sda_line = m_sda & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    int vld_cnt = 0;
    logic [7:0] last_byte = '0;
    logic       last_rs = 1'b0;
    logic       last_oe_after = 1'b0;

    always #2 clk = ~clk;

    i2c_rx_regsel dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .dev_id_i(dev_id), .sda_oe_o(sda_oe), .byte_vld_o(byte_vld),
        .byte_o(byte_out), .regsel_o(regsel));

    always @(negedge clk) begin
        if (byte_vld) begin
            vld_cnt   <= vld_cnt + 1;
            last_byte <= byte_out;
            last_rs   <= regsel;
        end
    end

    function automatic bit exp_select(input logic [7:0] a, input logic [5:0] id);
        return (a[7:2] == id) && (a[0] == 1'b0);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H/2);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(H/2); m_sda = 1'b0; tick(H/2);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked, output bit oe_held);
        for (int i = 7; i >= 0; i--) begin
            tick(H/2); m_sda = b[i]; tick(H/2);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0;
        end
        tick(H/2); m_sda = 1'b1; tick(H/2);
        oe_held = sda_oe;
        m_scl = 1'b1; tick(H/2);
        acked = ~sda_line;
        oe_held = oe_held & sda_oe;
        tick(H/2);
        m_scl = 1'b0;
        tick(H/2 - 1);
        last_oe_after = sda_oe;
        #0;
    endtask

    task automatic transfer(input logic [7:0] addr, input int nbytes, input bit end_stop);
        bit sel, ack, held;
        int v0;
        logic [7:0] d;
        sel = exp_select(addr, dev_id);
        send_byte(addr, ack, held);
        check(ack == sel, addr[0] ? "R3" : "R2", "address ack", ack, sel);
        if (sel) begin
            check(held, "R5", "oe held in ninth clock", held, 1);
            check(!last_oe_after, "R9", "oe released after ack", last_oe_after, 0);
        end
        for (int k = 0; k < nbytes; k++) begin
            d = 8'($urandom);
            v0 = vld_cnt;
            send_byte(d, ack, held);
            check(ack == sel, "R5", "data ack", ack, sel);
            check((vld_cnt - v0) == int'(sel), "R6", "strobe count", vld_cnt - v0, sel);
            if (sel) begin
                check(last_byte == d, "R6", "byte value", last_byte, d);
                check(last_rs == addr[1], "R4", "register select", last_rs, addr[1]);
            end
        end
        if (end_stop) begin
            bus_stop();
            check(!sda_oe, "R7", "released after stop", sda_oe, 0);
        end
    endtask

    task automatic repeated_start();
        tick(H/2); m_sda = 1'b1; tick(H/2);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ack, held;
        int v0;
        logic [7:0] a;
        void'($urandom(32'd7411));
        tick(3);
        check(!sda_oe && !byte_vld, "R8", "outputs in reset", {sda_oe, byte_vld}, 0);
        rst_n = 1'b1;
        tick(4);
        check(!sda_oe && !byte_vld, "R8", "outputs after reset", {sda_oe, byte_vld}, 0);

        // instruction transfer, several bytes (R4, R6, R7)
        bus_start(); transfer({dev_id, 1'b0, 1'b0}, 4, 1'b1);
        // data transfer (R4)
        bus_start(); transfer({dev_id, 1'b1, 1'b0}, 3, 1'b1);
        // ID mismatch, then ignored bytes (R2)
        bus_start(); transfer({dev_id ^ 6'b000100, 1'b0, 1'b0}, 2, 1'b1);
        // read bit set (R3)
        bus_start(); transfer({dev_id, 1'b1, 1'b1}, 2, 1'b1);
        // mismatch then repeated start with match (R1, R2)
        bus_start(); transfer({dev_id ^ 6'b100000, 1'b1, 1'b0}, 1, 1'b0);
        repeated_start(); transfer({dev_id, 1'b1, 1'b0}, 2, 1'b0);
        // repeated start mid-payload switches select (R1, R4)
        repeated_start(); transfer({dev_id, 1'b0, 1'b0}, 2, 1'b1);
        // bytes after stop without start are ignored (R7)
        v0 = vld_cnt;
        m_scl = 1'b0;
        send_byte(8'hA5, ack, held);
        check(!ack, "R7", "no ack after stop", ack, 0);
        check(vld_cnt == v0, "R7", "no strobe after stop", vld_cnt - v0, 0);
        bus_stop();

        // constrained random transfers
        for (int t = 0; t < 24; t++) begin
            dev_id = 6'($urandom);
            if (($urandom % 10) < 7)
                a = {dev_id, 1'($urandom), 1'b0};
            else
                a = 8'($urandom);
            bus_start();
            transfer(a, 1 + int'($urandom % 4), 1'b1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule